// File: doc/BRIEF.md
# Segment LCD Scan Controller with Pixel Blink

This block scans a multiplexed segment LCD. A frame timer, stepped by a 32768 Hz tick through a programmable divider, selects one common at a time. For that common it takes one bit from each segment's 4-bit pixel group in a local segment memory and drives a digital level per segment. An external analog bias stage turns the common-select flags, the drive phase and the segment levels into pad voltages. The panel runs either with four commons (1/4 duty) or with three commons (1/3 duty). The drive phase inverts after every complete scan of the active commons, so the panel sees no DC bias.

Two designated segment drivers, 18 and 19 by default, can blink chosen pixels. Each has a 4-bit mask with one bit per common. While the blink clock is in its off half, masked pixels show as off. In the on half they show their memory value. One control bit sets the blink rate to 1 Hz or 0.5 Hz. A simple register port writes and reads the segment memory, the duty and rate controls, the divider and the masks. The segment memory has no reset, so it keeps its contents through reset and can serve as general storage.

Top module: `seg_lcd_scanner`

## Requirements
- R1: After reset, common 0 is active, drivePhase is 0, and the control, divider and mask registers read 0. This means 1/4 duty, a 0.5 Hz blink rate, a divider of 0 and no blinking pixels.
- R2: The register map is as follows.
  - Addresses 0 to NUM_SEGS-1 hold the pixel group of each segment. Bit k of a group is the pixel on common k. Only bits 3:0 are stored, and bits 7:4 read as 0.
  - Address NUM_SEGS is the control register: bit 0 selects 1/3 duty and bit 1 selects the 1 Hz blink rate.
  - Address NUM_SEGS+1 holds the divider in its low DIV_W bits.
  - Address NUM_SEGS+2 holds the blink masks: bits 3:0 for the first blink segment and bits 7:4 for the second.
  - Every other address reads 0. Read data is combinational from the address.
- R3: The segment memory keeps its contents while rstN is asserted and after rstN is released.
- R4: On each tick, the slot counter advances, or clears if it has already reached or passed the divider value. The active common moves on only on the tick that clears the counter, so each common holds for divider+1 ticks. At most one common flag is set at any time.
- R5: In 1/4 duty, the commons are selected in the order 0, 1, 2, 3. After common 3 the scan returns to 0 and drivePhase inverts.
- R6: In 1/3 duty, the scan runs 0, 1, 2 and then back to 0 with a phase inversion. Common 3's flag is never set, and bit 3 of every pixel group has no effect.
- R7: Each segment level equals the segment's pixel bit for the active common, XOR drivePhase. With no active common, the pixel bit counts as 0.
- R8: For the two blink segments, a pixel whose mask bit is set shows as off during the off half of the blink period. During the on half it shows its memory value.
- R9: The blink clock counts ticks from reset, and the first half of each period is the on half. At the 1 Hz rate, each half lasts TICK_HZ/2 ticks. At the 0.5 Hz rate, each half lasts TICK_HZ ticks.
- R10: Blink masks have no effect on any segment other than the two blink segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset (does not clear the segment memory) |
| tickIn | input | 1 | One-cycle strobe at the 32768 Hz timebase rate |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| comActive | output | 4 | One flag per common; set while that common is being driven |
| drivePhase | output | 1 | Drive polarity of the current half-frame |
| segLevel | output | NUM_SEGS | Per-segment level, pixel XOR drivePhase |

## Verification
The bench builds the block with TICK_HZ = 64, NUM_SEGS = 24, ADDR_W = 5 and DIV_W = 3. The short tick rate puts full blink periods at both rates within a few hundred ticks. The 3-bit divider lets random divider writes land below the current slot count, which exercises the wrap path. With 24 segments, both blink drivers and their non-blinking neighbours stay in the map, and every segment address can be visited many times during a random run with duty mode switching.

// File: rtl/seg_lcd_pkg.sv
package seg_lcd_pkg;

  localparam int COM_COUNT = 4;
  localparam int COM_IDX_W = $clog2(COM_COUNT);
  localparam int DATA_W    = 8;

  // configuration handed from the register block to the scan logic
  typedef struct packed {
    logic                          thirdDuty;
    logic                          fastBlink;
    logic [1:0][COM_COUNT-1:0]     blinkMask;
  } scanCfg_t;

  // strobes and state handed from the scan control to the datapath
  typedef struct packed {
    logic [COM_IDX_W-1:0] comIdx;
    logic                 comValid;
    logic                 drivePhase;
    logic                 blinkOn;
  } scanState_t;

endpackage

// File: rtl/seg_lcd_regs.sv
module seg_lcd_regs
  import seg_lcd_pkg::*;
#(
  parameter int NUM_SEGS = 38,
  parameter int ADDR_W   = 6,
  parameter int DIV_W    = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               regWr,
  input  logic [ADDR_W-1:0]                  regAddr,
  input  logic [DATA_W-1:0]                  regWdata,
  output logic [DATA_W-1:0]                  regRdata,
  output scanCfg_t                           cfg,
  output logic [DIV_W-1:0]                   divLimit,
  output logic [NUM_SEGS-1:0][COM_COUNT-1:0] segMem
);

  localparam int SEG_IDX_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;
  localparam logic [ADDR_W-1:0] SEG_END   = ADDR_W'(NUM_SEGS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SEGS);
  localparam logic [ADDR_W-1:0] DIV_ADDR  = ADDR_W'(NUM_SEGS + 1);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_SEGS + 2);

  logic                 isSeg;
  logic [SEG_IDX_W-1:0] segIdx;

  always_comb begin
    isSeg  = regAddr < SEG_END;
    segIdx = regAddr[SEG_IDX_W-1:0];
  end

  // segment memory: deliberately without reset so contents are retained
  always_ff @(posedge clk) begin
    if (regWr && isSeg) segMem[segIdx] <= regWdata[COM_COUNT-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      divLimit <= '0;
    end else if (regWr) begin
      if (regAddr == CTRL_ADDR) begin
        cfg.thirdDuty <= regWdata[0];
        cfg.fastBlink <= regWdata[1];
      end
      if (regAddr == DIV_ADDR) divLimit <= regWdata[DIV_W-1:0];
      if (regAddr == MASK_ADDR) begin
        cfg.blinkMask[0] <= regWdata[COM_COUNT-1:0];
        cfg.blinkMask[1] <= regWdata[2*COM_COUNT-1:COM_COUNT];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (isSeg) begin
      regRdata[COM_COUNT-1:0] = segMem[segIdx];
    end else if (regAddr == CTRL_ADDR) begin
      regRdata[0] = cfg.thirdDuty;
      regRdata[1] = cfg.fastBlink;
    end else if (regAddr == DIV_ADDR) begin
      regRdata[DIV_W-1:0] = divLimit;
    end else if (regAddr == MASK_ADDR) begin
      regRdata[COM_COUNT-1:0]           = cfg.blinkMask[0];
      regRdata[2*COM_COUNT-1:COM_COUNT] = cfg.blinkMask[1];
    end
  end

  // R2: pixel group reads never carry bits above the common count
  assert_seg_read_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    isSeg |-> regRdata[DATA_W-1:COM_COUNT] == '0);

  // R2: a control write is visible on the next read of that address
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == CTRL_ADDR) |=> cfg.thirdDuty == $past(regWdata[0]));

endmodule

// File: rtl/seg_lcd_scan_ctrl.sv
module seg_lcd_scan_ctrl
  import seg_lcd_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int TICK_HZ = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  scanCfg_t         cfg,
  input  logic [DIV_W-1:0] divLimit,
  output scanState_t       scan
);

  // TICK_HZ is a power of two; one extra bit spans a 0.5 Hz period
  localparam int BLINK_W = $clog2(TICK_HZ) + 1;

  logic [DIV_W-1:0]     slotCnt;
  logic [COM_IDX_W-1:0] comIdx;
  logic [COM_IDX_W-1:0] lastCom;
  logic                 phase;
  logic [BLINK_W-1:0]   blinkCnt;
  logic                 slotDone;
  logic                 scanWrap;

  always_comb begin
    lastCom  = cfg.thirdDuty ? COM_IDX_W'(COM_COUNT - 2) : COM_IDX_W'(COM_COUNT - 1);
    slotDone = tickIn && (slotCnt >= divLimit);
    scanWrap = slotDone && (comIdx >= lastCom);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt  <= '0;
      comIdx   <= '0;
      phase    <= 1'b0;
      blinkCnt <= '0;
    end else begin
      if (tickIn) begin
        slotCnt  <= slotDone ? '0 : slotCnt + 1'b1;
        blinkCnt <= blinkCnt + 1'b1;
      end
      if (slotDone) comIdx <= scanWrap ? '0 : comIdx + 1'b1;
      if (scanWrap) phase <= ~phase;
    end
  end

  always_comb begin
    scan.comIdx     = comIdx;
    scan.comValid   = !(cfg.thirdDuty && comIdx == COM_IDX_W'(COM_COUNT - 1));
    scan.drivePhase = phase;
    scan.blinkOn    = cfg.fastBlink ? !blinkCnt[BLINK_W-2] : !blinkCnt[BLINK_W-1];
  end

  // R4: without a tick the common selection holds
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> $stable(comIdx));

  // R5: the phase only inverts as the scan restarts at common 0
  assert_phase_at_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |-> comIdx == '0);

  // R6: in 1/3 duty an advance never lands on the last common
  assert_third_skips_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (slotDone && cfg.thirdDuty) |=> comIdx != COM_IDX_W'(COM_COUNT - 1));

endmodule

// File: rtl/seg_lcd_datapath.sv
module seg_lcd_datapath
  import seg_lcd_pkg::*;
#(
  parameter int NUM_SEGS    = 38,
  parameter int BLINK_SEG_A = 18,
  parameter int BLINK_SEG_B = 19
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  scanState_t                         scan,
  input  scanCfg_t                           cfg,
  input  logic [NUM_SEGS-1:0][COM_COUNT-1:0] segMem,
  output logic [COM_COUNT-1:0]               comActive,
  output logic                               drivePhase,
  output logic [NUM_SEGS-1:0]                segLevel
);

  for (genvar c = 0; c < COM_COUNT; c++) begin : g_com
    assign comActive[c] = scan.comValid && (scan.comIdx == COM_IDX_W'(c));
  end

  assign drivePhase = scan.drivePhase;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic rawPixel;
    assign rawPixel = scan.comValid && segMem[g][scan.comIdx];

    if (g == BLINK_SEG_A || g == BLINK_SEG_B) begin : g_blink
      localparam int SLOT = (g == BLINK_SEG_A) ? 0 : 1;
      logic hidePixel;
      assign hidePixel   = !scan.blinkOn && cfg.blinkMask[SLOT][scan.comIdx];
      assign segLevel[g] = (rawPixel && !hidePixel) ^ scan.drivePhase;

      // R8: in the on half a blink segment shows its stored pixel
      assert_blink_on_half_R8: assert property (@(posedge clk) disable iff (!rstN)
        scan.blinkOn |-> segLevel[g] == ((scan.comValid && segMem[g][scan.comIdx]) ^ drivePhase));
    end else begin : g_plain
      assign segLevel[g] = rawPixel ^ scan.drivePhase;
    end
  end

  // R4: never more than one common driven
  assert_one_common_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comActive));

endmodule

// File: rtl/seg_lcd_scanner.sv
module seg_lcd_scanner
  import seg_lcd_pkg::*;
#(
  parameter int NUM_SEGS    = 38,
  parameter int ADDR_W      = 6,
  parameter int DIV_W       = 8,
  parameter int TICK_HZ     = 32768,
  parameter int BLINK_SEG_A = 18,
  parameter int BLINK_SEG_B = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickIn,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [7:0]           regWdata,
  output logic [7:0]           regRdata,
  output logic [3:0]           comActive,
  output logic                 drivePhase,
  output logic [NUM_SEGS-1:0]  segLevel
);

  scanCfg_t                           cfg;
  scanState_t                         scan;
  logic [DIV_W-1:0]                   divLimit;
  logic [NUM_SEGS-1:0][COM_COUNT-1:0] segMem;

  seg_lcd_regs #(
    .NUM_SEGS(NUM_SEGS), .ADDR_W(ADDR_W), .DIV_W(DIV_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cfg(cfg),
    .divLimit(divLimit), .segMem(segMem)
  );

  seg_lcd_scan_ctrl #(
    .DIV_W(DIV_W), .TICK_HZ(TICK_HZ)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .cfg(cfg),
    .divLimit(divLimit), .scan(scan)
  );

  seg_lcd_datapath #(
    .NUM_SEGS(NUM_SEGS), .BLINK_SEG_A(BLINK_SEG_A), .BLINK_SEG_B(BLINK_SEG_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .scan(scan), .cfg(cfg), .segMem(segMem),
    .comActive(comActive), .drivePhase(drivePhase), .segLevel(segLevel)
  );

endmodule

// File: tb/seg_lcd_scanner_bench.sv
module seg_lcd_scanner_bench;

  localparam int NS   = 24;
  localparam int AW   = 5;
  localparam int DW   = 3;
  localparam int THZ  = 64;
  localparam int BW   = $clog2(THZ) + 1;
  localparam int SEGA = 18;
  localparam int SEGB = 19;
  localparam int CTRL = NS;
  localparam int DIVA = NS + 1;
  localparam int MSKA = NS + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickIn = 1'b0;
  logic          regWr = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic [3:0]    comActive;
  logic          drivePhase;
  logic [NS-1:0] segLevel;

  int checks = 0;
  int fails  = 0;
  bit memKnown = 1'b0;

  // bench model state
  logic [3:0]    mMem [NS];
  logic          mThird, mFast;
  logic [DW-1:0] mDiv, mSlot;
  logic [3:0]    mMaskA, mMaskB;
  logic [1:0]    mCom;
  logic          mPhase;
  logic [BW-1:0] mBlink;

  seg_lcd_scanner #(
    .NUM_SEGS(NS), .ADDR_W(AW), .DIV_W(DW), .TICK_HZ(THZ),
    .BLINK_SEG_A(SEGA), .BLINK_SEG_B(SEGB)
  ) u_seg_lcd_scanner (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .comActive(comActive),
    .drivePhase(drivePhase), .segLevel(segLevel)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic expBlinkOn();
    return mFast ? !mBlink[BW-2] : !mBlink[BW-1];
  endfunction

  function automatic logic [3:0] expCom();
    logic [3:0] v = '0;
    if (!(mThird && mCom == 2'd3)) v[mCom] = 1'b1;
    return v;
  endfunction

  function automatic logic expPixel(input int s);
    logic p;
    p = !(mThird && mCom == 2'd3) && mMem[s][mCom];
    if (!expBlinkOn()) begin
      if (s == SEGA && mMaskA[mCom]) p = 1'b0;
      if (s == SEGB && mMaskB[mCom]) p = 1'b0;
    end
    return p;
  endfunction

  task automatic modelReset();
    mThird = 0; mFast = 0; mDiv = '0; mSlot = '0; mMaskA = '0; mMaskB = '0;
    mCom = '0; mPhase = 0; mBlink = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk);
    modelReset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic compareOutputs();
    logic [NS-1:0] expPlain, expBl, mskBl;
    chk(comActive == expCom(), mThird ? "R6 common" : "R4 common", 64'(comActive), 64'(expCom()));
    chk(drivePhase == mPhase, "R5 phase", 64'(drivePhase), 64'(mPhase));
    if (memKnown) begin
      expPlain = '0; expBl = '0; mskBl = '0;
      for (int s = 0; s < NS; s++) begin
        if (s == SEGA || s == SEGB) begin
          mskBl[s] = 1'b1; expBl[s] = expPixel(s) ^ mPhase;
        end else expPlain[s] = expPixel(s) ^ mPhase;
      end
      chk((segLevel & ~mskBl) == expPlain, mThird ? "R6 segments" : "R7 segments",
          64'(segLevel & ~mskBl), 64'(expPlain));
      chk((segLevel & mskBl) == expBl, "R8 blink segments", 64'(segLevel & mskBl), 64'(expBl));
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic tk, input logic wr, input int a, input logic [7:0] d);
    tickIn = tk; regWr = wr; regAddr = AW'(a); regWdata = d;
    @(posedge clk);
    if (tk) begin
      if (mSlot >= mDiv) begin
        mSlot = '0;
        if (mCom >= (mThird ? 2'd2 : 2'd3)) begin mCom = '0; mPhase = !mPhase; end
        else mCom = mCom + 2'd1;
      end else mSlot = mSlot + 1'b1;
      mBlink = mBlink + 1'b1;
    end
    if (wr) begin
      if (a < NS) mMem[a] = d[3:0];
      else if (a == CTRL) begin mThird = d[0]; mFast = d[1]; end
      else if (a == DIVA) mDiv = d[DW-1:0];
      else if (a == MSKA) begin mMaskA = d[3:0]; mMaskB = d[7:4]; end
    end
    @(negedge clk);
    tickIn = 1'b0; regWr = 1'b0;
    compareOutputs();
  endtask

  task automatic readChk(input int a, input logic [7:0] exp, input string tag);
    regAddr = AW'(a);
    #1;
    chk(regRdata == exp, tag, 64'(regRdata), 64'(exp));
  endtask

  initial begin
    logic [3:0] snap [NS];
    void'($urandom(32'd4242));
    modelReset();
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(comActive == 4'b0001, "R1 common after reset", 64'(comActive), 64'h1);
    chk(drivePhase == 1'b0, "R1 phase after reset", 64'(drivePhase), 64'h0);
    readChk(CTRL, 8'h00, "R1 control reset");
    readChk(DIVA, 8'h00, "R1 divider reset");
    readChk(MSKA, 8'h00, "R1 mask reset");

    // fill memory, upper bits dropped (R2)
    for (int s = 0; s < NS; s++) step(1'b0, 1'b1, s, 8'($urandom()) | 8'hA0);
    memKnown = 1'b1;
    for (int s = 0; s < NS; s++) readChk(s, {4'h0, mMem[s]}, "R2 segment readback");
    for (int a = NS + 3; a < (1 << AW); a++) readChk(a, 8'h00, "R2 unmapped read");
    step(1'b0, 1'b1, DIVA, 8'hFD);
    readChk(DIVA, 8'h05, "R2 divider readback");
    step(1'b0, 1'b1, MSKA, 8'h6C);
    readChk(MSKA, 8'h6C, "R2 mask readback");
    step(1'b0, 1'b1, CTRL, 8'hFE);
    readChk(CTRL, 8'h02, "R2 control readback");

    // R4/R5 directed: divider 2, each common holds three ticks, order 0..3 then phase flip
    doReset();
    step(1'b0, 1'b1, DIVA, 8'h02);
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < 3; t++) begin
        chk(comActive == 4'(1 << c), "R4 slot hold", 64'(comActive), 64'(1 << c));
        step(1'b1, 1'b0, 0, 8'h00);
      end
    end
    chk(comActive == 4'b0001 && drivePhase, "R5 wrap to common 0 inverted",
        64'({drivePhase, comActive}), 64'h11);

    // random run
    for (int i = 0; i < 2500; i++) begin
      int a;
      logic wr;
      wr = ($urandom() % 12) == 0;
      a = int'($urandom() % (NS + 3));
      step(1'($urandom()), wr, a, 8'($urandom()));
    end

    // R3 retention across reset
    for (int s = 0; s < NS; s++) snap[s] = mMem[s];
    doReset();
    for (int s = 0; s < NS; s++) readChk(s, {4'h0, snap[s]}, "R3 retained segment");

    // R6 directed: 1/3 duty, flip bit 3 of every group mid-run
    step(1'b0, 1'b1, CTRL, 8'h01);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 0, 8'h00);
    for (int s = 0; s < NS; s++) step(1'b0, 1'b1, s, {4'h0, mMem[s] ^ 4'h8});
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 0, 8'h00);
      chk(comActive[3] == 1'b0, "R6 fourth common idle", 64'(comActive[3]), 64'h0);
    end

    // R9/R10 directed: 1 Hz rate
    doReset();
    step(1'b0, 1'b1, SEGA, 8'h0F);
    step(1'b0, 1'b1, SEGA - 1, 8'h0F);
    step(1'b0, 1'b1, SEGB + 1, 8'h0F);
    step(1'b0, 1'b1, SEGB, 8'h0F);
    step(1'b0, 1'b1, MSKA, 8'h0F);
    step(1'b0, 1'b1, CTRL, 8'h02);
    for (int i = 0; i < THZ / 2 - 1; i++) step(1'b1, 1'b0, 0, 8'h00);
    chk((segLevel[SEGA] ^ drivePhase) == 1'b1, "R9 fast last on tick", 64'(segLevel[SEGA] ^ drivePhase), 64'h1);
    step(1'b1, 1'b0, 0, 8'h00);
    chk((segLevel[SEGA] ^ drivePhase) == 1'b0, "R9 fast first off tick", 64'(segLevel[SEGA] ^ drivePhase), 64'h0);
    chk((segLevel[SEGA-1] ^ drivePhase) == 1'b1, "R10 neighbour below", 64'(segLevel[SEGA-1] ^ drivePhase), 64'h1);
    chk((segLevel[SEGB+1] ^ drivePhase) == 1'b1, "R10 neighbour above", 64'(segLevel[SEGB+1] ^ drivePhase), 64'h1);
    chk((segLevel[SEGB] ^ drivePhase) == 1'b1, "R8 unmasked blink segment", 64'(segLevel[SEGB] ^ drivePhase), 64'h1);

    // R9 directed: 0.5 Hz rate, second blink segment
    doReset();
    step(1'b0, 1'b1, MSKA, 8'hF0);
    for (int i = 0; i < THZ - 1; i++) step(1'b1, 1'b0, 0, 8'h00);
    chk((segLevel[SEGB] ^ drivePhase) == 1'b1, "R9 slow last on tick", 64'(segLevel[SEGB] ^ drivePhase), 64'h1);
    step(1'b1, 1'b0, 0, 8'h00);
    chk((segLevel[SEGB] ^ drivePhase) == 1'b0, "R9 slow first off tick", 64'(segLevel[SEGB] ^ drivePhase), 64'h0);
    for (int i = 0; i < THZ; i++) step(1'b1, 1'b0, 0, 8'h00);
    chk((segLevel[SEGB] ^ drivePhase) == 1'b1, "R9 slow back on", 64'(segLevel[SEGB] ^ drivePhase), 64'h1);

    // second random run with mixed modes
    for (int i = 0; i < 2500; i++) begin
      int a;
      logic wr;
      wr = ($urandom() % 8) == 0;
      a = ($urandom() % 4 == 0) ? CTRL + int'($urandom() % 3) : int'($urandom() % NS);
      step(($urandom() % 4) != 0, wr, a, 8'($urandom()));
    end

    summary();
    $finish;
  end

endmodule